// File: doc/BRIEF.md
# Converter Calibration Sequencer

This block decides when the analog calibration of a sampling converter runs and tracks it while it runs. After power-up, modelled here by the synchronous reset, it counts a settling delay. The length of that delay is picked by a select input from two parameterised powers of two. When the count ends it launches the first calibration. Later calibrations are launched by a pin pattern: the request input must be sampled low for a full qualifying window and then high for a full qualifying window.

A power-down request interacts with both paths. While power-down is asserted, the settling counter is frozen. A completed request pattern seen in power-down is dropped and not remembered. A power-down request that arrives during a calibration is granted only once that calibration has finished. The analog trim is outside the block: a one-cycle done pulse ends each run.

While a calibration runs, the block holds a running flag and a data-invalid flag. It gives a one-cycle start strobe when a run begins. It raises an internal-clock-stop indication when phase adjustment is enabled and resistor trimming is not disabled at the moment a run begins.

Top module: `cal_seq_ctrl`

## Requirements
- R1: With no power-down, the first calibration starts after 2^SHORT_DLY_W clock edges from reset release when `cal_dly_i` is 0, or after 2^LONG_DLY_W edges when it is 1. `cal_run_o` is first high after edge count + 1.
- R2: While `pd_i` is high in the power-up phase, the settling counter does not advance. `pd_granted_o` is high and no calibration starts. Counting resumes from where it stopped when `pd_i` falls.
- R3: A command is valid when `cal_i` is sampled low on at least PAT_LEN consecutive edges and then high on PAT_LEN consecutive edges. `cal_run_o` is high from the edge after the PAT_LEN-th high sample.
- R4: A high sample before the low window is complete discards the low count. A low sample during the high window discards the high count and also the low qualification, so a new full low window is needed.
- R5: If `cal_i` is high on the first edge after reset release, the power-up calibration is blocked. Only a valid command pattern starts a calibration.
- R6: A command pattern that completes while power-down is requested or granted starts nothing. The detector is cleared while power-down is granted, so the pattern is not remembered after `pd_i` falls.
- R7: `pd_granted_o` is never high while `cal_run_o` is high. If `pd_i` is high during a run, `pd_granted_o` rises on the same edge on which `cal_run_o` falls.
- R8: `cal_run_o` stays high until `cal_done_i` is sampled high, and it falls on that edge. This applies to runs started by power-up and to runs started by command.
- R9: `data_invalid_o` is high in every cycle in which `cal_run_o` is high.
- R10: `clk_stop_o` is high for a run exactly when `phase_adj_en_i`=1 and `trim_dis_i`=0 on the edge that starts the run. It is low outside runs.
- R11: `cal_start_o` is high only in the first cycle of each run, for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| cal_i | input | 1 | Calibration command pin |
| cal_dly_i | input | 1 | Settling delay select: 0 short, 1 long |
| pd_i | input | 1 | Power-down request |
| phase_adj_en_i | input | 1 | Clock phase adjustment enabled |
| trim_dis_i | input | 1 | Resistor trim disabled |
| cal_done_i | input | 1 | One-cycle pulse ending the analog calibration |
| cal_run_o | output | 1 | Calibration running |
| cal_start_o | output | 1 | One-cycle strobe at the start of a run |
| data_invalid_o | output | 1 | Conversion data and range flag invalid |
| pd_granted_o | output | 1 | Power-down in effect |
| clk_stop_o | output | 1 | Internal clock stopped for this run |

## Verification
Some properties are checked on every cycle. These are that power-down and running never overlap, that a deferred power-down is granted as the run ends, that a run holds until done, that data-invalid covers the run, and that the clock-stop flag only appears inside a run. The start strobe is checked to be one cycle long and to never follow a cycle with power-down requested. Other behaviour needs the bench's scenarios. These cover the exact length of both settling delays, the counter freezing under power-down, the blocking by a high pin at power-up, the restart rules of the pattern detector, and a pattern being forgotten after power-down.

// File: rtl/cal_seq_pkg.sv
// Shared types for the calibration sequencer.
package cal_seq_pkg;

    // Sequencer phases: waiting out power-up settling, idle, calibrating.
    typedef enum logic [1:0] {
        SEQ_PU_WAIT = 2'd0,
        SEQ_IDLE    = 2'd1,
        SEQ_RUN     = 2'd2
    } seq_state_e;

endpackage

// File: rtl/cal_pu_timer.sv
// Power-up settling timer.
// Counts enabled cycles up to 2^SHORT_W or 2^LONG_W (picked by long_sel)
// and then raises a sticky expired flag. Assumes the enable is dropped
// by the caller whenever power-down is requested. The count holds while
// disabled and does not restart.
module cal_pu_timer #(
    parameter int SHORT_W = 25,
    parameter int LONG_W  = 31
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic long_sel,
    output logic expired_o
);
    localparam int CW = LONG_W + 1;
    localparam logic [CW-1:0] SHORT_LAST = (CW'(1) << SHORT_W) - CW'(1);
    localparam logic [CW-1:0] LONG_LAST  = (CW'(1) << LONG_W) - CW'(1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    // Terminal count for the selected delay.
    always_comb begin
        last = long_sel ? LONG_LAST : SHORT_LAST;
    end

    // Advance the count while enabled; latch expiry at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            expired_o <= 1'b0;
        end else if (run_en && !expired_o) begin
            if (cnt_q >= last) begin
                expired_o <= 1'b1;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    // Expiry is sticky until the next reset (R1).
    p_expiry_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |=> expired_o);

    // Without enable, expiry cannot newly appear (R2).
    p_frozen_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !expired_o) |=> !expired_o);

endmodule

// File: rtl/cal_pattern_det.sv
// Command pattern detector for the calibration pin.
// Emits a one-cycle pulse once the pin has been sampled low on PAT_LEN
// consecutive edges and then high on PAT_LEN consecutive edges. A high
// sample before the low window fills discards the low count. A low
// sample during the high window restarts qualification from that sample.
// The clear input wipes all progress; the caller holds it in power-down.
module cal_pattern_det #(
    parameter int PAT_LEN = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic pin_i,
    output logic seen_o
);
    localparam int CW = $clog2(PAT_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(PAT_LEN);

    logic [CW-1:0] low_cnt_q;
    logic [CW-1:0] high_cnt_q;
    logic          low_ok;

    // Low window qualified once the saturating count is full.
    always_comb begin
        low_ok = (low_cnt_q == FULL);
    end

    // Track the low window, then the high window, and pulse on completion.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            low_cnt_q  <= '0;
            high_cnt_q <= '0;
            seen_o     <= 1'b0;
        end else if (!pin_i) begin
            seen_o     <= 1'b0;
            high_cnt_q <= '0;
            if (high_cnt_q != '0) begin
                low_cnt_q <= CW'(1);
            end else if (!low_ok) begin
                low_cnt_q <= low_cnt_q + CW'(1);
            end
        end else if (!low_ok) begin
            seen_o    <= 1'b0;
            low_cnt_q <= '0;
        end else if (high_cnt_q + CW'(1) == FULL) begin
            seen_o     <= 1'b1;
            low_cnt_q  <= '0;
            high_cnt_q <= '0;
        end else begin
            seen_o     <= 1'b0;
            high_cnt_q <= high_cnt_q + CW'(1);
        end
    end

    // A completed pattern is reported for one cycle only (R3).
    p_seen_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seen_o |=> !seen_o);

    // Completion is always caused by a high sample (R4).
    p_seen_after_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seen_o) |-> $past(pin_i));

endmodule

// File: rtl/cal_seq_fsm.sv
// Calibration sequencing state machine.
// Launches a run from the settling timer (power-up phase only, unless the
// pin was high at power-up) or from a command pattern. Refuses to launch
// while power-down is requested, defers power-down until a run completes,
// and ends a run on the external done pulse.
module cal_seq_fsm
    import cal_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic pd_i,
    input  logic phase_adj_en_i,
    input  logic trim_dis_i,
    input  logic cal_done_i,
    input  logic pat_seen_i,
    input  logic timer_exp_i,
    output logic timer_en_o,
    output logic det_clear_o,
    output logic cal_run_o,
    output logic cal_start_o,
    output logic data_invalid_o,
    output logic pd_granted_o,
    output logic clk_stop_o
);
    seq_state_e state_q;
    seq_state_e state_d;
    logic       first_q;
    logic       pu_block_q;
    logic       start_now;
    logic       pu_go;

    // Launch decision: timer path only in the power-up phase.
    always_comb begin
        pu_go     = (state_q == SEQ_PU_WAIT) && timer_exp_i && !pu_block_q;
        start_now = (state_q != SEQ_RUN) && !pd_i && (pat_seen_i || pu_go);
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        if (start_now) begin
            state_d = SEQ_RUN;
        end else if (state_q == SEQ_RUN && cal_done_i) begin
            state_d = SEQ_IDLE;
        end
    end

    // Helper outputs to the timer and the detector.
    always_comb begin
        timer_en_o  = (state_q == SEQ_PU_WAIT) && !pd_i;
        det_clear_o = pd_granted_o;
    end

    // Capture whether the pin was high on the first edge after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q    <= 1'b1;
            pu_block_q <= 1'b0;
        end else if (first_q) begin
            first_q    <= 1'b0;
            pu_block_q <= pin_i;
        end
    end

    // State register and registered status outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= SEQ_PU_WAIT;
            cal_start_o    <= 1'b0;
            data_invalid_o <= 1'b0;
            pd_granted_o   <= 1'b0;
            clk_stop_o     <= 1'b0;
        end else begin
            state_q        <= state_d;
            cal_start_o    <= start_now;
            data_invalid_o <= (state_d == SEQ_RUN);
            pd_granted_o   <= pd_i && (state_d != SEQ_RUN);
            if (start_now) begin
                clk_stop_o <= phase_adj_en_i && !trim_dis_i;
            end else if (state_d != SEQ_RUN) begin
                clk_stop_o <= 1'b0;
            end
        end
    end

    // Running flag straight from the state register.
    always_comb begin
        cal_run_o = (state_q == SEQ_RUN);
    end

    // Power-down and calibration never overlap (R7).
    p_pd_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pd_granted_o && cal_run_o));

    // A deferred power-down is granted as the run ends (R7).
    p_pd_deferred_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_run_o && cal_done_i && pd_i) |=> pd_granted_o);

    // A run holds until done (R8).
    p_run_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_run_o && !cal_done_i) |=> cal_run_o);

    // A run ends on the done pulse (R8).
    p_run_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_run_o && cal_done_i) |=> !cal_run_o);

    // Data is flagged invalid for the whole run (R9).
    p_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cal_run_o |-> data_invalid_o);

    // Clock stop only inside a run (R10).
    p_clkstop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop_o |-> cal_run_o);

    // Start strobe marks the first run cycle and lasts one cycle (R11).
    p_start_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start_o |-> (cal_run_o && !$past(cal_run_o)));
    p_start_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start_o |=> !cal_start_o);

    // No launch follows a cycle with power-down requested (R6).
    p_no_start_pd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pd_i |=> !cal_start_o);

endmodule

// File: rtl/cal_seq_ctrl.sv
// Top of the converter calibration sequencer.
// Joins the power-up settling timer, the command pattern detector and the
// sequencing state machine. All logic is on one clock with a synchronous
// active-low reset that stands for power-up.
module cal_seq_ctrl #(
    parameter int SHORT_DLY_W = 25,
    parameter int LONG_DLY_W  = 31,
    parameter int PAT_LEN     = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cal_i,
    input  logic cal_dly_i,
    input  logic pd_i,
    input  logic phase_adj_en_i,
    input  logic trim_dis_i,
    input  logic cal_done_i,
    output logic cal_run_o,
    output logic cal_start_o,
    output logic data_invalid_o,
    output logic pd_granted_o,
    output logic clk_stop_o
);
    logic timer_en;
    logic timer_exp;
    logic det_clear;
    logic pat_seen;

    cal_pu_timer #(
        .SHORT_W (SHORT_DLY_W),
        .LONG_W  (LONG_DLY_W)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (timer_en),
        .long_sel  (cal_dly_i),
        .expired_o (timer_exp)
    );

    cal_pattern_det #(
        .PAT_LEN (PAT_LEN)
    ) det_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (det_clear),
        .pin_i  (cal_i),
        .seen_o (pat_seen)
    );

    cal_seq_fsm fsm_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .pin_i          (cal_i),
        .pd_i           (pd_i),
        .phase_adj_en_i (phase_adj_en_i),
        .trim_dis_i     (trim_dis_i),
        .cal_done_i     (cal_done_i),
        .pat_seen_i     (pat_seen),
        .timer_exp_i    (timer_exp),
        .timer_en_o     (timer_en),
        .det_clear_o    (det_clear),
        .cal_run_o      (cal_run_o),
        .cal_start_o    (cal_start_o),
        .data_invalid_o (data_invalid_o),
        .pd_granted_o   (pd_granted_o),
        .clk_stop_o     (clk_stop_o)
    );

endmodule

// File: tb/cal_seq_ctrl_tb_top.sv
// Bench for the calibration sequencer: directed scenarios mixed with
// seeded random durations and control bits.
module cal_seq_ctrl_tb_top;
    localparam int SW  = 4;
    localparam int LW  = 6;
    localparam int PAT = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cal = 1'b0, cal_dly = 1'b0, pd = 1'b0, pa = 1'b0, td = 1'b0, done = 1'b0;
    logic run, start, inval, pdg, cstop;
    int   errors = 0;
    int   checks = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    cal_seq_ctrl #(.SHORT_DLY_W(SW), .LONG_DLY_W(LW), .PAT_LEN(PAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cal_i(cal), .cal_dly_i(cal_dly), .pd_i(pd),
        .phase_adj_en_i(pa), .trim_dis_i(td), .cal_done_i(done),
        .cal_run_o(run), .cal_start_o(start), .data_invalid_o(inval),
        .pd_granted_o(pdg), .clk_stop_o(cstop)
    );

    function automatic int exp_delay(input logic sel);
        return sel ? (1 << LW) : (1 << SW);
    endfunction

    function automatic logic exp_stop(input logic a, input logic b);
        return a && !b;
    endfunction

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #5;
        end
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic c, input logic d, input logic p);
        cal = c; cal_dly = d; pd = p; done = 1'b0;
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        tick(1);
        done = 1'b0;
        check("R8 run ends on done", run, 1'b0);
    endtask

    task automatic pattern(input int lo, input int hi);
        cal = 1'b0; tick(lo);
        cal = 1'b1; tick(hi);
    endtask

    initial begin
        void'($urandom(32'd4711));
        cal = 1'b0; cal_dly = 1'b0; pd = 1'b0;
        rst_n = 1'b0;
        tick(3);
        check("reset run", run, 1'b0);
        check("reset start", start, 1'b0);
        check("reset invalid", inval, 1'b0);
        check("reset pd", pdg, 1'b0);
        check("reset clkstop", cstop, 1'b0);

        // R1 short delay, R11 strobe, R9 invalid, R8 hold
        rst_n = 1'b1;
        tick(exp_delay(1'b0));
        check("R1 short not yet", run, 1'b0);
        tick(1);
        check("R1 short started", run, 1'b1);
        check("R11 strobe first cycle", start, 1'b1);
        check("R9 invalid during run", inval, 1'b1);
        tick(1);
        check("R11 strobe one cycle", start, 1'b0);
        tick(1 + int'($urandom % 20));
        check("R8 run held", run, 1'b1);
        check("R9 invalid held", inval, 1'b1);
        finish_run();
        check("R9 invalid after run", inval, 1'b0);

        // R1 long delay
        do_reset(1'b0, 1'b1, 1'b0);
        tick(exp_delay(1'b1));
        check("R1 long not yet", run, 1'b0);
        tick(1);
        check("R1 long started", run, 1'b1);
        finish_run();

        // R2 power-down freezes the settling count
        do_reset(1'b0, 1'b0, 1'b1);
        tick(40);
        check("R2 no run in pd", run, 1'b0);
        check("R2 pd granted", pdg, 1'b1);
        pd = 1'b0;
        tick(exp_delay(1'b0));
        check("R2 still counting", run, 1'b0);
        check("R2 pd released", pdg, 1'b0);
        tick(1);
        check("R2 started after pd", run, 1'b1);
        finish_run();

        // R5 pin high at power-up blocks, pattern then starts (R3)
        do_reset(1'b1, 1'b0, 1'b0);
        tick(100);
        check("R5 blocked", run, 1'b0);
        pattern(PAT, PAT);
        check("R3 not before edge", run, 1'b0);
        tick(1);
        check("R3 R5 pattern started", run, 1'b1);
        finish_run();

        // R4 short low window discarded
        pattern(10 + int'($urandom % 70), PAT);
        tick(1);
        check("R4 short low ignored", run, 1'b0);
        // R4 low inside high window forces a new low window
        pattern(PAT, 50);
        pattern(5, PAT);
        tick(1);
        check("R4 broken high ignored", run, 1'b0);
        pattern(PAT, PAT);
        check("R3 idle not yet", run, 1'b0);
        tick(1);
        check("R3 idle started", run, 1'b1);
        finish_run();

        // R6 pattern in power-down is dropped and forgotten
        pd = 1'b1;
        tick(2);
        check("R6 pd granted", pdg, 1'b1);
        pattern(PAT, PAT);
        tick(3);
        check("R6 no run in pd", run, 1'b0);
        pd = 1'b0;
        tick(5);
        check("R6 not remembered", run, 1'b0);

        // R7 power-down deferred during run
        pattern(PAT, PAT);
        tick(1);
        check("R7 run before pd", run, 1'b1);
        pd = 1'b1;
        tick(5);
        check("R7 pd deferred", pdg, 1'b0);
        check("R7 run continues", run, 1'b1);
        done = 1'b1;
        tick(1);
        done = 1'b0;
        check("R7 run ended", run, 1'b0);
        check("R7 pd granted at end", pdg, 1'b1);
        pd = 1'b0;
        tick(1);
        check("R7 pd released", pdg, 1'b0);

        // R10 clock stop for random control bits plus the enabling corner
        for (int k = 0; k < 5; k++) begin
            logic a, b;
            a = (k == 0) ? 1'b1 : logic'($urandom % 2);
            b = (k == 0) ? 1'b0 : logic'($urandom % 2);
            pa = a; td = b;
            pattern(PAT, PAT);
            tick(1);
            pa = ~a; td = ~b;
            check("R10 run for stop test", run, 1'b1);
            check("R10 clk stop at start", cstop, exp_stop(a, b));
            tick(3);
            check("R10 clk stop held", cstop, exp_stop(a, b));
            finish_run();
            check("R10 clk stop cleared", cstop, 1'b0);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule